// File: doc/BRIEF.md
# Saturating Wide-Dividend Integer Divider

This block divides a double-width dividend by a single-width divisor and returns a single-width quotient, for either unsigned or two's-complement signed operands. The upper half of the dividend comes from a separate high-word input and the lower half from the first operand. The second operand is the divisor. A caller raises `start` for one cycle while the block is idle. `busy` then stays high while the quotient is built one bit per cycle. A one-cycle `done` pulse marks the point at which `quotient`, `overflow` and `divZero` take their new values.

A quotient that does not fit in the result width is never wrapped. It is clamped to the nearest representable limit, and `overflow` is raised. A zero divisor skips the iteration entirely and reports only the divide-by-zero flag. In signed mode, the most negative dividend has a dedicated path that always clamps.

Top module: `sat_divider`

## Requirements
- R1: The dividend is `{hiWord, opA}` (hiWord in the upper W bits) and the divisor is `opB`; both operands are captured in the cycle `start` is accepted.
- R2: Unsigned mode (`opSigned`=0): when floor(dividend/divisor) fits in W bits, `quotient` is that value and `overflow` is 0.
- R3: Unsigned mode: when the true quotient exceeds 2^W-1, `quotient` is all ones and `overflow` is 1.
- R4: Signed mode (`opSigned`=1): dividend and divisor are two's complement, division truncates toward zero, and a quotient in [-2^(W-1), 2^(W-1)-1] is returned exactly with `overflow` 0.
- R5: Signed mode: a true quotient above 2^(W-1)-1 gives 0 followed by W-1 ones, and one below -2^(W-1) gives 1 followed by W-1 zeros; `overflow` is 1 in both cases.
- R6: Signed mode with dividend 1 followed by 2W-1 zeros: a negative divisor gives the positive limit and a non-negative divisor gives the negative limit, always with `overflow` 1.
- R7: A zero divisor, in either mode, gives `divZero` 1, `quotient` 0 and `overflow` 0; any nonzero divisor gives `divZero` 0.
- R8: For a nonzero divisor, `done` is high exactly 2W+2 rising edges after the edge that accepts `start`; for a zero divisor, 2 edges. `busy` is high from the edge after acceptance until `done`. `done` lasts one cycle and coincides with `busy` low.
- R9: `start` raised while `busy` is high is ignored: neither the result nor the completion time of the operation in flight changes, and no extra `done` follows.
- R10: `quotient`, `overflow` and `divZero` change only in a cycle where `done` is high.
- R11: After reset, `busy`, `done`, `quotient`, `overflow` and `divZero` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opSigned | input | 1 | 1 = signed division, 0 = unsigned |
| hiWord | input | W | Upper half of the dividend |
| opA | input | W | Lower half of the dividend |
| opB | input | W | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Result, saturated |
| overflow | output | 1 | Quotient was clamped |
| divZero | output | 1 | Divisor was zero |

## Verification
The checker monitors the handshake and hold rules on every cycle. These are the single-cycle `done` pulse, `busy` after acceptance, outputs frozen between pulses, and a zero-divisor result that is clean. It also checks that every saturated result is one of the legal limit values for the mode captured at acceptance. Whether a given quotient is arithmetically right, which limit applies, the special most-negative path, the exact latency, and the rejection of a start while busy can only be shown by the bench's sweeps. The bench covers every dividend and divisor of a 4-bit configuration in both modes.

// File: rtl/sat_div_pkg.sv
package sat_div_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // capture operands, set up magnitudes
    logic step;    // one restoring shift-subtract iteration
    logic finish;  // saturate and register the result
  } ctlStrobes_t;
endpackage

// File: rtl/sat_div_ctrl.sv
module sat_div_ctrl
  import sat_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        inZero,
  output ctlStrobes_t ctl,
  output logic        busy,
  output logic        done
);
  localparam int STEPS = 2 * W;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;
  state_t state, stateNext;
  logic [CW-1:0] stepCnt;

  always_comb begin
    stateNext  = state;
    ctl        = '0;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.load  = 1'b1;
        stateNext = inZero ? S_FIN : S_RUN;
      end
      S_RUN: begin
        ctl.step = 1'b1;
        if (stepCnt == LAST) stateNext = S_FIN;
      end
      S_FIN: begin
        ctl.finish = 1'b1;
        stateNext  = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= ctl.finish;
      if (ctl.load)      stepCnt <= '0;
      else if (ctl.step) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/sat_div_dp.sv
module sat_div_dp
  import sat_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctlStrobes_t  ctl,
  input  logic         opSigned,
  input  logic [W-1:0] hiWord,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         inZero,
  output logic [W-1:0] quotient,
  output logic         overflow,
  output logic         divZero
);
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] ONE_D   = DW'(1);
  localparam logic [W-1:0]  ONE_W   = W'(1);
  localparam logic [W-1:0]  POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0]  NEG_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [DW-1:0] DVD_MIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] NEG_LIM = {{W{1'b0}}, NEG_MIN};

  // operand conditioning
  logic [DW-1:0] dvdIn, dvdMag;
  logic [W-1:0]  dsrMag;
  logic          dvdNeg, dsrNeg;

  assign dvdIn  = {hiWord, opA};
  assign dvdNeg = opSigned & dvdIn[DW-1];
  assign dsrNeg = opSigned & opB[W-1];
  assign dvdMag = dvdNeg ? (~dvdIn + ONE_D) : dvdIn;
  assign dsrMag = dsrNeg ? (~opB + ONE_W) : opB;
  assign inZero = (opB == '0);

  // iteration state
  logic [W-1:0]  remR, dsrR;
  logic [DW-1:0] quoR;
  logic          sgnR, negQR, minR, dsrNegR, zeroR;

  logic [W:0]    shifted, trial;
  logic          takeBit;

  assign shifted = {remR, quoR[DW-1]};
  assign trial   = shifted - {1'b0, dsrR};
  assign takeBit = ~trial[W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR <= '0; dsrR <= '0; quoR <= '0;
      sgnR <= 1'b0; negQR <= 1'b0; minR <= 1'b0; dsrNegR <= 1'b0; zeroR <= 1'b0;
    end else if (ctl.load) begin
      remR    <= '0;
      dsrR    <= dsrMag;
      quoR    <= dvdMag;
      sgnR    <= opSigned;
      negQR   <= dvdNeg ^ dsrNeg;
      minR    <= opSigned & (dvdIn == DVD_MIN);
      dsrNegR <= dsrNeg;
      zeroR   <= inZero;
    end else if (ctl.step) begin
      remR <= takeBit ? trial[W-1:0] : shifted[W-1:0];
      quoR <= {quoR[DW-2:0], takeBit};
    end
  end

  // saturation
  logic [W-1:0] resQ;
  logic         resOv;
  logic         hiClear;

  assign hiClear = (quoR[DW-1:W] == '0);

  always_comb begin
    resQ  = quoR[W-1:0];
    resOv = 1'b0;
    if (zeroR) begin
      resQ = '0;
    end else if (!sgnR) begin
      if (!hiClear) begin
        resQ  = '1;
        resOv = 1'b1;
      end
    end else if (minR) begin
      resQ  = dsrNegR ? POS_MAX : NEG_MIN;
      resOv = 1'b1;
    end else if (negQR) begin
      if (quoR <= NEG_LIM) resQ = ~quoR[W-1:0] + ONE_W;
      else begin
        resQ  = NEG_MIN;
        resOv = 1'b1;
      end
    end else if (!hiClear || quoR[W-1]) begin
      resQ  = POS_MAX;
      resOv = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quotient <= '0;
      overflow <= 1'b0;
      divZero  <= 1'b0;
    end else if (ctl.finish) begin
      quotient <= resQ;
      overflow <= resOv;
      divZero  <= zeroR;
    end
  end
endmodule

// File: rtl/sat_divider.sv
module sat_divider
  import sat_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         opSigned,
  input  logic [W-1:0] hiWord,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic         overflow,
  output logic         divZero
);
  ctlStrobes_t ctl;
  logic        inZero;

  sat_div_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inZero(inZero),
    .ctl(ctl), .busy(busy), .done(done)
  );

  sat_div_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opSigned(opSigned),
    .hiWord(hiWord), .opA(opA), .opB(opB), .inZero(inZero),
    .quotient(quotient), .overflow(overflow), .divZero(divZero)
  );
endmodule

// File: rtl/sat_divider_chk.sv
module sat_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         opSigned,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic         overflow,
  input logic         divZero
);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  // mode of the operation in flight, tracked from the ports
  logic modeLat;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeLat <= 1'b0;
    else if (start && !busy) modeLat <= opSigned;
  end

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(quotient) && $stable(overflow) && $stable(divZero)));
  a_r7_zero_clean: assert property (@(posedge clk) disable iff (!rstN)
    divZero |-> (quotient == '0 && !overflow));
  a_r3_unsigned_sat: assert property (@(posedge clk) disable iff (!rstN)
    (done && overflow && !modeLat) |-> (quotient == '1));
  a_r5_signed_sat: assert property (@(posedge clk) disable iff (!rstN)
    (done && overflow && modeLat) |-> (quotient == POS_MAX || quotient == NEG_MIN));
endmodule

bind sat_divider sat_divider_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .opSigned(opSigned), .busy(busy),
  .done(done), .quotient(quotient), .overflow(overflow), .divZero(divZero)
);

// File: tb/sim_sat_divider.sv
`timescale 1ns/1ps
module sim_sat_divider;
  localparam int W  = 4;
  localparam int DW = 2 * W;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic         opSigned = 1'b0;
  logic [W-1:0] hiWord = '0, opA = '0, opB = '0;
  logic         busy, done, overflow, divZero;
  logic [W-1:0] quotient;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sat_divider #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .opSigned(opSigned),
    .hiWord(hiWord), .opA(opA), .opB(opB), .busy(busy), .done(done),
    .quotient(quotient), .overflow(overflow), .divZero(divZero)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [W-1:0] h, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic s, input bit poke);
    longint ud, sd, sb, q;
    logic [W-1:0] expQ;
    logic expOv, expDz;
    string tag;
    int cyc, expLat;
    ud = longint'({h, a});
    sd = ud[DW-1] ? ud - (longint'(1) << DW) : ud;
    sb = b[W-1] ? longint'(b) - (longint'(1) << W) : longint'(b);
    expOv = 1'b0; expDz = 1'b0; expQ = '0; expLat = DW + 2;
    if (b == '0) begin
      expDz = 1'b1; tag = "R7"; expLat = 2;
    end else if (!s) begin
      q = ud / longint'(b);
      if (q > (longint'(1) << W) - 1) begin expQ = '1; expOv = 1'b1; tag = "R3"; end
      else begin expQ = q[W-1:0]; tag = "R1 R2"; end
    end else if (sd == -(longint'(1) << (DW - 1))) begin
      expOv = 1'b1; tag = "R6";
      expQ = (sb < 0) ? {1'b0, {(W-1){1'b1}}} : {1'b1, {(W-1){1'b0}}};
    end else begin
      q = sd / sb;
      if (q > (longint'(1) << (W - 1)) - 1) begin
        expQ = {1'b0, {(W-1){1'b1}}}; expOv = 1'b1; tag = "R5";
      end else if (q < -(longint'(1) << (W - 1))) begin
        expQ = {1'b1, {(W-1){1'b0}}}; expOv = 1'b1; tag = "R5";
      end else begin
        expQ = q[W-1:0]; tag = "R4";
      end
    end

    @(negedge clk);
    hiWord = h; opA = a; opB = b; opSigned = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    if (poke) check(busy == 1'b1, "R8 busy", longint'(busy), 1);
    while (!done && cyc < 100) begin
      if (poke && cyc == 3) begin
        // R9: a competing request with different operands while busy
        start = 1'b1; hiWord = ~h; opB = '0; opSigned = ~s;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(cyc == expLat, poke ? "R9 R8 latency" : "R8 latency", cyc, expLat);
    check(quotient == expQ && overflow == expOv && divZero == expDz,
          poke ? {"R9 ", tag} : tag,
          longint'({divZero, overflow, quotient}), longint'({expDz, expOv, expQ}));
    check(!busy, "R8 idle at done", longint'(busy), 0);
    if (poke) begin
      repeat (4) begin
        @(negedge clk);
        check(!done && !busy, "R9 no extra done", longint'({done, busy}), 0);
      end
      check(quotient == expQ && overflow == expOv && divZero == expDz, "R10 hold",
            longint'({divZero, overflow, quotient}), longint'({expDz, expOv, expQ}));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && quotient == '0 && !overflow && !divZero, "R11 reset",
          longint'({busy, done, overflow, divZero, quotient}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R11 after release", longint'({busy, done}), 0);

    // directed: busy-start rejection and hold
    runOp(4'h3, 4'h5, 4'h7, 1'b0, 1'b1);
    runOp(4'hF, 4'h9, 4'h3, 1'b1, 1'b1);
    runOp(4'h8, 4'h0, 4'hF, 1'b1, 1'b1);

    // exhaustive sweep of the small configuration
    for (int s = 0; s < 2; s++)
      for (int h = 0; h < (1 << W); h++)
        for (int a = 0; a < (1 << W); a++)
          for (int b = 0; b < (1 << W); b++)
            runOp(W'(h), W'(a), W'(b), s[0], 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule